// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Input Capture

This block timestamps transitions on four input pins. It takes a free-running counter value from elsewhere in the chip. Each pin first passes through its own synchronizer. When a transition of the selected polarity appears, the channel copies the counter value into that channel's 16-bit capture register and raises that channel's capture flag. Software sets the polarity for all four channels with a single 8-bit control write. A flag stays set until its channel receives a clear strobe.

The fourth channel shares its pin with an output-compare function that lives outside this block. It captures only while a mode input selects capture. It is the only channel that can raise an interrupt request, which is qualified by an enable input. The channels have no arbitration between them, so any number of them can record the same counter value in the same cycle.

Top module: `edge_capture_unit`

## Requirements
- R1: Each channel's 2-bit polarity field selects the trigger: 00 turns the channel off, 01 captures on low-to-high transitions only, 10 on high-to-low only, and 11 on both.
- R2: The control byte places the field of channel 4 (port index 3) in bits 7:6, channel 1 (index 0) in bits 5:4, channel 2 (index 1) in bits 3:2 and channel 3 (index 2) in bits 1:0. The higher bit of each field is the more significant bit of the code. A control write takes effect on the clock edge where `ctl_wr` is high.
- R3: After reset the control byte is 00h, so every channel is off. All capture registers read zero, all flags are clear and `cap_irq` is low.
- R4: A pin change driven before clock edge k is detected after two synchronizer stages. The capture register takes the `tick_val` present at edge k+2, and the flag rises on that same edge.
- R5: Channels act independently. Transitions on several pins in the same cycle latch the same counter value in each of those channels.
- R6: Channel 4 (index 3) neither captures nor raises its flag while `ch4_cap_mode` is low, whatever its field holds.
- R7: `cap_irq` is high exactly when `ch4_irq_en` is high, `ch4_cap_mode` is high and the flag of channel 4 is set.
- R8: A flag stays set until `flag_clr` for that channel is high at a clock edge. If a capture and a clear meet on the same edge, the flag stays set.
- R9: A capture register never changes while its channel is off. Pin activity on a channel that is off leaves both its register and its flag untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_val | input | 16 | Free-running counter value to be captured |
| cap_pin | input | 4 | Asynchronous capture pins, index 0 = channel 1 |
| ctl_wr | input | 1 | Write strobe for the polarity control byte |
| ctl_wdata | input | 8 | Control byte write data |
| flag_clr | input | 4 | Per-channel flag clear strobes |
| ch4_cap_mode | input | 1 | High: channel 4 acts as input capture |
| ch4_irq_en | input | 1 | Interrupt enable for channel 4 |
| cap_val | output | 64 | Capture registers, channel i in bits 16i+15:16i |
| cap_flag | output | 4 | Capture flags |
| cap_irq | output | 1 | Interrupt request from channel 4 |

## Verification
Assertions check several properties on every cycle. An off channel never triggers, a capture register holds while its channel is disarmed, and a trigger loads the counter and raises the flag one edge later. A lone clear drops the flag, channel 4 cannot gain a flag while its mode input is low, and the interrupt never appears without mode, enable and flag all present. Some behaviour can be shown only by the bench's scenarios. These are the exact three-edge latency from pin to register, the field placement inside the control byte, and whether each polarity code reacts to each transition direction. The bench also shows that simultaneous transitions share one timestamp and that a capture wins over a clear on the same edge.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = 2;
  localparam int CTL_W  = NUM_CH * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // Low bit of a channel's polarity field inside the control byte.
  // The shared channel sits on top; the others follow downward by index.
  function automatic int sel_lsb(input int ch);
    if (ch == NUM_CH - 1) return CTL_W - SEL_W;
    return CTL_W - 2 * SEL_W - ch * SEL_W;
  endfunction
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ecap_edge_det.sv
module ecap_edge_det
  import ecap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  logic      arm,
  input  edge_sel_e sel,
  output logic      hit
);
  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  always_comb begin
    prev_d = lvl;
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
    hit    = 1'b0;
    if (arm) begin
      unique case (sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_ANY:  hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R1
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_OFF) |-> !hit);
  // R1
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == EDGE_RISE) |-> lvl);
  // R1
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel == EDGE_FALL) |-> !lvl);
endmodule

// File: rtl/ecap_slot.sv
module ecap_slot #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr,
  input  logic [CW-1:0] tick,
  output logic [CW-1:0] cap_q,
  output logic          flag_q
);
  logic [CW-1:0] cap_d;
  logic          flag_d;

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) begin
      cap_d  = tick;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (flag_q && cap_q == $past(tick)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(flag_q));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        tick_val,
  input  logic [NUM_CH-1:0]    cap_pin,
  input  logic                 ctl_wr,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic [NUM_CH-1:0]    flag_clr,
  input  logic                 ch4_cap_mode,
  input  logic                 ch4_irq_en,
  output logic [NUM_CH*CW-1:0] cap_val,
  output logic [NUM_CH-1:0]    cap_flag,
  output logic                 cap_irq
);
  localparam int SHARED = NUM_CH - 1;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Polarity control byte.
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ctl_q <= '0;
    else             ctl_q <= ctl_d;
  end

  logic [NUM_CH-1:0] arm;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] lvl;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int FL = sel_lsb(g);
    edge_sel_e sel;
    assign sel = edge_sel_e'(ctl_q[FL+SEL_W-1:FL]);

    if (g == SHARED) begin : g_shared
      assign arm[g] = (sel != EDGE_OFF) && ch4_cap_mode;
    end else begin : g_plain
      assign arm[g] = (sel != EDGE_OFF);
    end

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_core_n),
      .d     (cap_pin[g]),
      .q     (lvl[g])
    );

    ecap_edge_det u_det (
      .clk   (clk),
      .rst_n (rst_core_n),
      .lvl   (lvl[g]),
      .arm   (arm[g]),
      .sel   (sel),
      .hit   (hit[g])
    );

    ecap_slot #(.CW(CW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .hit    (hit[g]),
      .clr    (flag_clr[g]),
      .tick   (tick_val),
      .cap_q  (cap_val[g*CW +: CW]),
      .flag_q (cap_flag[g])
    );

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      !arm[g] |=> $stable(cap_val[g*CW +: CW]));
  end

  always_comb begin
    cap_irq = ch4_irq_en & ch4_cap_mode & cap_flag[SHARED];
  end

  // R6
  shared_gate_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ch4_cap_mode |=> !$rose(cap_flag[SHARED]));
  // R7
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    cap_irq |-> (cap_flag[SHARED] && ch4_cap_mode && ch4_irq_en));
  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ch4_irq_en && ch4_cap_mode && cap_flag[SHARED]) |-> cap_irq);
endmodule

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tick_val = 16'h1230;
  logic [3:0]  cap_pin;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic [3:0]  flag_clr;
  logic        ch4_cap_mode;
  logic        ch4_irq_en;
  logic [63:0] cap_val;
  logic [3:0]  cap_flag;
  logic        cap_irq;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] exp_cap [4];

  always #4 clk = ~clk;
  always @(posedge clk) tick_val <= tick_val + 16'd1;

  edge_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_val(tick_val), .cap_pin(cap_pin),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flag_clr(flag_clr),
    .ch4_cap_mode(ch4_cap_mode), .ch4_irq_en(ch4_irq_en),
    .cap_val(cap_val), .cap_flag(cap_flag), .cap_irq(cap_irq)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic clr_all();
    flag_clr = 4'hF;
    step();
    flag_clr = 4'h0;
  endtask

  // Field position per R2: index 3 at bit 6, index 0/1/2 at bits 4/2/0.
  function automatic logic [7:0] field(input int ch, input int code);
    int lsb = (ch == 3) ? 6 : 4 - 2 * ch;
    return 8'(code << lsb);
  endfunction

  task automatic check_caps(input string req);
    for (int c = 0; c < 4; c++) check(req, 32'(cap_val[c*16 +: 16]), 32'(exp_cap[c]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] t0;
    rst_n = 1'b0; cap_pin = 4'h0; ctl_wr = 1'b0; ctl_wdata = 8'h00;
    flag_clr = 4'h0; ch4_cap_mode = 1'b1; ch4_irq_en = 1'b1;
    for (int c = 0; c < 4; c++) exp_cap[c] = 16'h0000;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R3: reset state
    check("R3 flags", 32'(cap_flag), 32'h0);
    check("R3 irq", 32'(cap_irq), 32'h0);
    check_caps("R3 caps");
    // R3: control cleared, so pin activity captures nothing
    cap_pin = 4'hF; step(4); cap_pin = 4'h0; step(4);
    check("R3 disabled flags", 32'(cap_flag), 32'h0);
    check_caps("R3 disabled caps");

    // R1 R2 R4 R9: sweep channel x code x direction
    for (int ch = 0; ch < 4; ch++) begin
      for (int code = 0; code < 4; code++) begin
        for (int dir = 0; dir < 2; dir++) begin
          bit qual;
          wr_ctl(8'h00);
          cap_pin[ch] = (dir == 1);
          step(4);
          clr_all();
          wr_ctl(field(ch, code));
          cap_pin[ch] = (dir == 0);
          t0 = tick_val;
          step(3);
          qual = (code == 3) || (code == 1 && dir == 0) || (code == 2 && dir == 1);
          if (qual) exp_cap[ch] = t0 + 16'd2;
          check($sformatf("R1 flag ch%0d code%0d dir%0d", ch, code, dir),
                32'(cap_flag), qual ? (32'h1 << ch) : 32'h0);
          check($sformatf("R4 R9 cap ch%0d code%0d dir%0d", ch, code, dir),
                32'(cap_val[ch*16 +: 16]), 32'(exp_cap[ch]));
          if (ch == 3) check("R7 irq in sweep", 32'(cap_irq), 32'(qual));
        end
      end
    end

    // R5: simultaneous transitions share the timestamp
    wr_ctl(8'h00); cap_pin = 4'h0; step(4); clr_all();
    wr_ctl(8'h3F);
    cap_pin = 4'h7; t0 = tick_val;
    step(3);
    for (int c = 0; c < 3; c++) exp_cap[c] = t0 + 16'd2;
    check("R5 flags", 32'(cap_flag), 32'h7);
    check_caps("R5 caps");

    // R6: shared channel gated by mode
    clr_all();
    ch4_cap_mode = 1'b0;
    wr_ctl(8'hC0);
    cap_pin[3] = 1'b1; step(3);
    check("R6 no flag", 32'(cap_flag[3]), 32'h0);
    check("R6 cap held", 32'(cap_val[63:48]), 32'(exp_cap[3]));
    check("R7 irq off mode0", 32'(cap_irq), 32'h0);
    ch4_cap_mode = 1'b1; step();
    cap_pin[3] = 1'b0; t0 = tick_val; step(3);
    exp_cap[3] = t0 + 16'd2;
    check("R6 capture mode1", 32'(cap_val[63:48]), 32'(exp_cap[3]));
    check("R7 irq set", 32'(cap_irq), 32'h1);
    ch4_irq_en = 1'b0; step();
    check("R7 irq enable low", 32'(cap_irq), 32'h0);
    ch4_irq_en = 1'b1; ch4_cap_mode = 1'b0; step();
    check("R7 irq mode low", 32'(cap_irq), 32'h0);
    check("R6 flag kept", 32'(cap_flag[3]), 32'h1);

    // R8: clear alone, clear vs capture, stickiness
    ch4_cap_mode = 1'b1;
    flag_clr = 4'h8; step(); flag_clr = 4'h0;
    check("R8 clear", 32'(cap_flag[3]), 32'h0);
    cap_pin[3] = 1'b1; t0 = tick_val;
    step(2);
    flag_clr = 4'h8; step(); flag_clr = 4'h0;
    exp_cap[3] = t0 + 16'd2;
    check("R8 capture wins", 32'(cap_flag[3]), 32'h1);
    check("R8 cap value", 32'(cap_val[63:48]), 32'(exp_cap[3]));
    step(5);
    check("R8 sticky", 32'(cap_flag), 32'h8);

    // R9: all channels off, heavy pin activity
    wr_ctl(8'h00); clr_all();
    for (int k = 0; k < 6; k++) begin
      cap_pin = ~cap_pin; step(2);
    end
    step(3);
    check("R9 flags", 32'(cap_flag), 32'h0);
    check_caps("R9 caps");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule